// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of an eight-input analog-to-digital converter in a microcontroller. Software programs a set of control fields: the input to convert, the reference choice, one-shot or repeating operation, whether starts come from software or from an external pin, and a divider for the conversion clock. The block then drives the analog input select, the reference select and the sample-and-hold control. It times each conversion and captures the converter's 10-bit result when the conversion ends.

The conversion clock is the machine clock divided by (N+1), where N is the 4-bit divider field. A conversion always lasts 16 conversion-clock periods. A conversion starts either from a software write of the start bit or from a falling edge on an active-low external pin, which is synchronized first. In repeating mode, each conversion that ends starts the next one at once. Clearing the mode bit lets the conversion in flight finish and then stops.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the reference select is 0 (internal band-gap), the divider field is 0, busy is low, the input select is 0, and both the done pulse and the sticky done flag are low.
- R2: The input select output carries the channel captured when a conversion starts. It holds that value for the whole conversion even if the channel field is rewritten. While idle it shows the channel field.
- R3: The reference select output is 0 (internal) or 1 (external pair), following the last written reference bit.
- R4: When the external-trigger enable of a write is 0, a write with the start bit set begins a conversion, and busy reads 1 from the next cycle.
- R5: When the external-trigger enable is 1, software start bits are ignored. A conversion begins on a high-to-low transition of ext_start_n, with busy rising on the third clock edge after the pin goes low. A pin held low does not start a second conversion.
- R6: Busy stays high for exactly 16*(N+1) machine cycles per conversion. N is the divider value in force when the conversion started.
- R7: At the end of a conversion, result takes conv_data, conv_done pulses high for one cycle, and done_flag sets. A write with cfg_done_clr set clears done_flag.
- R8: In repeating mode (mode bit 1) a new conversion begins on the cycle the previous one ends, and busy stays high. After a write sets the mode bit to 0, the conversion in progress completes and busy then falls.
- R9: A start request that arrives while busy is high is ignored, and the running conversion keeps its timing and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for all control fields |
| cfg_chan | input | 3 | Channel to convert (0..7) |
| cfg_ref_ext | input | 1 | Reference choice: 0 internal, 1 external |
| cfg_cont | input | 1 | Mode: 0 one-shot, 1 repeating |
| cfg_ext_trig | input | 1 | 1 selects the external pin as start source |
| cfg_start | input | 1 | Software start bit |
| cfg_prescale | input | 4 | Divider N for the conversion clock |
| cfg_done_clr | input | 1 | Clears the sticky done flag |
| ext_start_n | input | 1 | Asynchronous active-low external start |
| conv_data | input | 10 | Converter output word |
| mux_sel | output | 3 | Analog input select |
| ref_sel | output | 1 | Reference select |
| sh_hold | output | 1 | Sample-and-hold in hold state |
| busy | output | 1 | Start/busy status |
| conv_done | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Captured conversion result |
| prescale_q | output | 4 | Current divider field |
| cont_q | output | 1 | Current mode bit |
| ext_trig_q | output | 1 | Current start-source bit |

## Verification
The assertions check on every cycle that a completion pulse follows a busy cycle and never lasts two cycles, and that the input select holds steady inside a conversion. They also check that a one-shot completion drops busy, that the period counter moves only on conversion-clock ticks, and that synchronized pin edges never repeat on consecutive cycles. Only the bench scenarios can show the exact 16*(N+1) conversion length for every divider value, the captured result and reference per channel, and the pin latency. The same holds for ignored starts while busy, the held-low pin not retriggering, and the ordered shutdown of repeating mode.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int CH_W     = 3;
  localparam int PSC_W    = 4;
  localparam int RES_W    = 10;
  localparam int PERIODS  = 16;

  // machine cycles spent in one conversion for divider value n
  function automatic int conv_cycles(input int n);
    return PERIODS * (n + 1);
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PSC_W-1:0] div_n,
  output logic             tick
);
  logic [PSC_W-1:0] cnt;

  assign tick = en && (cnt == div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R6
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/adc_conv_timer.sv
`timescale 1ns/1ps
module adc_conv_timer #(
  parameter int PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(PERIODS);
  localparam logic [CW-1:0] LAST_IDX = CW'(PERIODS - 1);

  logic [CW-1:0] per_cnt;

  assign last = tick && (per_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_cnt <= '0;
    else if (start)  per_cnt <= '0;
    else if (tick)   per_cnt <= last ? '0 : per_cnt + 1'b1;
  end

  // R6
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(per_cnt));
endmodule

// File: rtl/adc_trig_sync.sv
`timescale 1ns/1ps
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 && !s2;

  // R5
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_ref_ext,
  input  logic             cfg_cont,
  input  logic             cfg_ext_trig,
  input  logic             cfg_start,
  input  logic [PSC_W-1:0] cfg_prescale,
  input  logic             cfg_done_clr,
  input  logic             ext_start_n,
  input  logic [RES_W-1:0] conv_data,
  output logic [CH_W-1:0]  mux_sel,
  output logic             ref_sel,
  output logic             sh_hold,
  output logic             busy,
  output logic             conv_done,
  output logic             done_flag,
  output logic [RES_W-1:0] result,
  output logic [PSC_W-1:0] prescale_q,
  output logic             cont_q,
  output logic             ext_trig_q
);
  logic [CH_W-1:0]  chan_q, act_chan;
  logic [PSC_W-1:0] act_psc;
  logic             ref_q;

  // next field values: a write takes effect in the same cycle it is decided on
  logic [CH_W-1:0]  chan_nxt;
  logic [PSC_W-1:0] psc_nxt;
  logic             cont_nxt, ext_nxt;

  // named internal events
  logic pin_fall, sw_start, hw_start, new_start, complete, restart, load, tick;

  assign chan_nxt = cfg_wr ? cfg_chan     : chan_q;
  assign psc_nxt  = cfg_wr ? cfg_prescale : prescale_q;
  assign cont_nxt = cfg_wr ? cfg_cont     : cont_q;
  assign ext_nxt  = cfg_wr ? cfg_ext_trig : ext_trig_q;

  assign sw_start  = cfg_wr && cfg_start && !cfg_ext_trig && !busy;
  assign hw_start  = ext_trig_q && pin_fall && !busy;
  assign new_start = sw_start || hw_start;
  assign restart   = complete && cont_nxt;
  assign load      = new_start || restart;

  adc_trig_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (ext_start_n),
    .fall  (pin_fall)
  );

  adc_clk_div #(.PSC_W(PSC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .en    (busy),
    .div_n (act_psc),
    .tick  (tick)
  );

  adc_conv_timer #(.PERIODS(PERIODS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (load),
    .tick  (tick),
    .last  (complete)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q     <= '0;
      ref_q      <= 1'b0;
      prescale_q <= '0;
      cont_q     <= 1'b0;
      ext_trig_q <= 1'b0;
    end else if (cfg_wr) begin
      chan_q     <= cfg_chan;
      ref_q      <= cfg_ref_ext;
      prescale_q <= cfg_prescale;
      cont_q     <= cfg_cont;
      ext_trig_q <= cfg_ext_trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      act_chan  <= '0;
      act_psc   <= '0;
      conv_done <= 1'b0;
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      conv_done <= complete;
      if (load) begin
        busy     <= 1'b1;
        act_chan <= chan_nxt;
        act_psc  <= psc_nxt;
      end else if (complete) begin
        busy <= 1'b0;
      end
      if (complete) result <= conv_data;
      if (complete)                       done_flag <= 1'b1;
      else if (cfg_wr && cfg_done_clr)    done_flag <= 1'b0;
    end
  end

  assign mux_sel = busy ? act_chan : chan_q;
  assign ref_sel = ref_q;
  assign sh_hold = busy;

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !conv_done) |-> $stable(mux_sel));

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cont_q) |-> !busy);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !complete) |=> busy);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic       cfg_ref_ext = 1'b0;
  logic       cfg_cont = 1'b0;
  logic       cfg_ext_trig = 1'b0;
  logic       cfg_start = 1'b0;
  logic [3:0] cfg_prescale = '0;
  logic       cfg_done_clr = 1'b0;
  logic       ext_start_n = 1'b1;
  logic [9:0] conv_data = '0;
  logic [2:0] mux_sel;
  logic       ref_sel, sh_hold, busy, conv_done, done_flag, cont_q, ext_trig_q;
  logic [9:0] result;
  logic [3:0] prescale_q;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
    .cfg_ref_ext(cfg_ref_ext), .cfg_cont(cfg_cont), .cfg_ext_trig(cfg_ext_trig),
    .cfg_start(cfg_start), .cfg_prescale(cfg_prescale), .cfg_done_clr(cfg_done_clr),
    .ext_start_n(ext_start_n), .conv_data(conv_data), .mux_sel(mux_sel),
    .ref_sel(ref_sel), .sh_hold(sh_hold), .busy(busy), .conv_done(conv_done),
    .done_flag(done_flag), .result(result), .prescale_q(prescale_q),
    .cont_q(cont_q), .ext_trig_q(ext_trig_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      finish_run();
    end
  end

  task automatic wr(input int ch, input int rf, input int ct, input int ex,
                    input int st, input int ps, input int dc);
    @(negedge clk);
    cfg_chan = 3'(ch); cfg_ref_ext = 1'(rf); cfg_cont = 1'(ct);
    cfg_ext_trig = 1'(ex); cfg_start = 1'(st); cfg_prescale = 4'(ps);
    cfg_done_clr = 1'(dc); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_start = 1'b0; cfg_done_clr = 1'b0;
  endtask

  initial begin
    int cnt;
    int bad;
    int dn;
    int dcyc [3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ref_sel", ref_sel, 0);
    chk("R1 prescale", prescale_q, 0);
    chk("R1 mux_sel", mux_sel, 0);
    chk("R1 done_flag", done_flag, 0);
    chk("R1 conv_done", conv_done, 0);

    // R4 R6 R7 R3 R2: sweep every divider value, channel = n mod 8
    for (int n = 0; n < 16; n++) begin
      conv_data = 10'(n * 37 + (n % 8));
      wr(n % 8, n % 2, 0, 0, 1, n, 0);
      chk("R4 busy after write", busy, 1);
      chk("R2 mux_sel", mux_sel, n % 8);
      chk("R3 ref_sel", ref_sel, n % 2);
      chk("R2 sh_hold", sh_hold, 1);
      cnt = 0;
      while (busy && cnt < 1000) begin
        cnt++;
        @(negedge clk);
      end
      chk("R6 busy length", cnt, adc_seq_pkg::conv_cycles(n));
      chk("R7 conv_done", conv_done, 1);
      chk("R7 result", result, n * 37 + (n % 8));
      chk("R7 done_flag set", done_flag, 1);
      @(negedge clk);
      chk("R7 conv_done one cycle", conv_done, 0);
      chk("R7 done_flag sticky", done_flag, 1);
      wr(n % 8, n % 2, 0, 0, 0, n, 1);
      chk("R7 done_flag cleared", done_flag, 0);
    end

    // R9 R2: start while busy ignored, channel held
    conv_data = 10'h155;
    wr(2, 0, 0, 0, 1, 0, 0);
    cnt = 0; bad = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (mux_sel != 3'd2) bad++;
      if (cnt == 5) begin
        cfg_chan = 3'd5; cfg_prescale = 4'd3; cfg_start = 1'b1; cfg_wr = 1'b1;
      end else begin
        cfg_wr = 1'b0; cfg_start = 1'b0;
      end
      @(negedge clk);
    end
    cfg_wr = 1'b0; cfg_start = 1'b0;
    chk("R9 busy length unchanged", cnt, 16);
    chk("R2 channel held in conversion", bad, 0);
    chk("R9 result", result, 10'h155);
    chk("R2 idle mux_sel shows field", mux_sel, 5);
    chk("R9 field written", prescale_q, 3);
    repeat (20) @(negedge clk);
    chk("R9 no late start", busy, 0);

    // R8 continuous mode with N=1, then stop
    conv_data = 10'h2AA;
    wr(1, 0, 1, 0, 1, 1, 1);
    cnt = 0; dn = 0; bad = 0;
    while (cnt < 400) begin
      cnt++;
      if (conv_done) begin
        if (dn < 3) dcyc[dn] = cnt;
        dn++;
      end
      if (conv_done && cnt < 90 && !busy) bad++;
      if (cnt == 66) begin
        cfg_chan = 3'd1; cfg_cont = 1'b0; cfg_prescale = 4'd1; cfg_wr = 1'b1;
      end else cfg_wr = 1'b0;
      if (!busy) break;
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    chk("R8 completions", dn, 3);
    chk("R8 first done", dcyc[0], 33);
    chk("R8 second done", dcyc[1], 65);
    chk("R8 third done", dcyc[2], 97);
    chk("R8 busy held across restart", bad, 0);
    chk("R8 stopped", busy, 0);
    chk("R8 result", result, 10'h2AA);
    repeat (40) @(negedge clk);
    chk("R8 stays stopped", busy, 0);

    // R5 external trigger
    wr(4, 1, 0, 1, 1, 0, 1);
    chk("R5 sw start ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk("R5 sw start ignored later", busy, 0);
    ext_start_n = 1'b0;
    @(negedge clk); chk("R5 sync stage 1", busy, 0);
    @(negedge clk); chk("R5 sync stage 2", busy, 0);
    @(negedge clk); chk("R5 start after edge", busy, 1);
    chk("R5 channel", mux_sel, 4);
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5 busy length", cnt, 16);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy) bad++;
      @(negedge clk);
    end
    chk("R5 held low no retrigger", bad, 0);
    ext_start_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_start_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 new edge starts", busy, 1);
    while (busy) @(negedge clk);
    ext_start_n = 1'b1;
    chk("R3 ref external", ref_sel, 1);
    chk("R1 ext field", ext_trig_q, 1);
    finish_run();
  end
endmodule